// File: doc/BRIEF.md
# Snooping Write-Invalidate Cache Line Controller

This block keeps a small direct-mapped, write-back cache coherent with other caches that share one snooping bus. Every line is in one of three states: Invalid (no data), Shared (clean, read only) or Exclusive (the only copy, writable and dirty). Processor loads and stores that hit complete locally. Misses win the bus through a request/grant pair and then issue a read-miss or write-miss command. When the line to be replaced is a dirty Exclusive block of another address, a write-back goes out first.

The same controller watches the commands that other caches put on the bus. A write miss to a block held Shared invalidates the line. A read miss or write miss to a block held Exclusive makes the controller supply the dirty word, raise the abort-memory output and drop the line to Shared or Invalid. Line state does not change while a request waits for the grant. A snoop that changes the waiting line wins, and the request is then evaluated again from scratch.

The controller states are IDLE (look up the request), WBREQ (wait for the grant to write back the victim), MISSREQ (wait for the grant to issue the miss), FILL (wait for the block data) and DONE (one-cycle acknowledge). The transitions are: IDLE→DONE on a hit; IDLE→WBREQ on a miss with a dirty victim; IDLE→MISSREQ on any other miss; WBREQ→MISSREQ on grant; WBREQ→IDLE and MISSREQ→IDLE on a snoop restart; MISSREQ→FILL on grant; FILL→DONE on fill data; DONE→IDLE.

Top module: `snoop_cache_ctrl`

## Requirements
- R1: After reset every line is Invalid, and cpu_ack, bus_req, bus_valid and snp_abort are low.
- R2: A load to an Invalid line issues one read-miss command (bus_cmd 1) for the load address. It returns the filled word, and the line becomes Shared.
- R3: A store to an Invalid or Shared line issues one write-miss command (bus_cmd 2) for the store address, and the line becomes Exclusive holding the store data. A store to a clean line counts as a miss.
- R4: A load that hits Shared or Exclusive, or a store that hits Exclusive, is acknowledged with no bus command. cpu_ack is a one-cycle pulse with cpu_rdata holding the line word, which is the store data for a store.
- R5: A miss whose line holds a different tag in Exclusive first issues a write-back command (bus_cmd 3) with the old address and data. The miss command follows it.
- R6: A snooped write miss from another cache to a block held Shared moves the line to Invalid without raising snp_abort.
- R7: A snooped read miss from another cache to a block held Exclusive raises snp_abort in the same cycle, drives the dirty word on snp_data, and moves the line to Shared.
- R8: A snooped write miss from another cache to a block held Exclusive raises snp_abort, drives the dirty word on snp_data, and moves the line to Invalid.
- R9: While a request waits for bus_gnt the line does not change. A snoop that changes the waiting line is applied first, and the request is then restarted from lookup.
- R10: A snooped command whose snp_src equals the cache's own identifier has no effect.
- R11: bus_valid is high only in a cycle where bus_gnt and bus_req are both high. bus_cmd encodes 1 read miss, 2 write miss and 3 write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request, held until cpu_ack |
| cpu_we | input | 1 | 1 store, 0 load |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Store data |
| cpu_ack | output | 1 | Request complete (one cycle) |
| cpu_rdata | output | DATA_W | Line word after the access |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant |
| bus_valid | output | 1 | Command driven this cycle |
| bus_cmd | output | 2 | Command code |
| bus_addr | output | ADDR_W | Command address |
| bus_data | output | DATA_W | Write-back data |
| fill_valid | input | 1 | Block data for the outstanding miss |
| fill_data | input | DATA_W | Block data |
| snp_valid | input | 1 | Snooped command present |
| snp_cmd | input | 2 | Snooped command code |
| snp_addr | input | ADDR_W | Snooped address |
| snp_src | input | SRC_W | Issuer of the snooped command |
| snp_abort | output | 1 | Cancel memory response, cache supplies data |
| snp_data | output | DATA_W | Dirty word supplied on a snoop |

## Verification
Loads and stores are applied to one index under each line state in turn: Invalid, Shared, Exclusive with a matching tag, and Exclusive with a foreign tag. The bus command stream shows apart a hit, a plain miss and a write-back followed by a miss. Snoops of both miss kinds are sent against Shared and Exclusive lines, and a snoop is sent with the cache's own identifier. Each snoop is followed by an access whose bus traffic shows the state it left. One request is held off the grant while a snoop takes its victim. The write-back that then goes missing shows that the request was restarted rather than resumed.

// File: rtl/scc_pkg.sv
package scc_pkg;
    typedef enum logic [1:0] {
        LS_INV = 2'd0,
        LS_SHR = 2'd1,
        LS_EXC = 2'd2
    } line_st_t;

    typedef enum logic [1:0] {
        BC_NONE   = 2'd0,
        BC_RDMISS = 2'd1,
        BC_WRMISS = 2'd2,
        BC_WRBACK = 2'd3
    } bus_cmd_t;

    typedef enum logic [2:0] {
        C_IDLE,
        C_WBREQ,
        C_MISSREQ,
        C_FILL,
        C_DONE
    } ctl_st_t;
endpackage

// File: rtl/scc_line_store.sv
module scc_line_store
    import scc_pkg::*;
#(
    parameter int LINES  = 8,
    parameter int IDX_W  = 3,
    parameter int TAG_W  = 7,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  c_idx,
    output line_st_t          c_st,
    output logic [TAG_W-1:0]  c_tag,
    output logic [DATA_W-1:0] c_data,
    input  logic [IDX_W-1:0]  s_idx,
    output line_st_t          s_st,
    output logic [TAG_W-1:0]  s_tag,
    output logic [DATA_W-1:0] s_data,
    input  logic              s_we,
    input  line_st_t          s_new_st,
    input  logic              u_we,
    input  logic [IDX_W-1:0]  u_idx,
    input  line_st_t          u_st,
    input  logic [TAG_W-1:0]  u_tag,
    input  logic [DATA_W-1:0] u_data
);
    line_st_t          st_q   [LINES];
    logic [TAG_W-1:0]  tag_q  [LINES];
    logic [DATA_W-1:0] data_q [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_line
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st_q[g]   <= LS_INV;
                tag_q[g]  <= '0;
                data_q[g] <= '0;
            end else if (u_we && u_idx == IDX_W'(g)) begin
                st_q[g]   <= u_st;
                tag_q[g]  <= u_tag;
                data_q[g] <= u_data;
            end else if (s_we && s_idx == IDX_W'(g)) begin
                st_q[g]   <= s_new_st;
            end
        end
    end

    assign c_st   = st_q[c_idx];
    assign c_tag  = tag_q[c_idx];
    assign c_data = data_q[c_idx];
    assign s_st   = st_q[s_idx];
    assign s_tag  = tag_q[s_idx];
    assign s_data = data_q[s_idx];
endmodule

// File: rtl/scc_snoop.sv
module scc_snoop
    import scc_pkg::*;
#(
    parameter int TAG_W  = 7,
    parameter int DATA_W = 16,
    parameter int SRC_W  = 2,
    parameter int MY_ID  = 0
) (
    input  logic              snp_valid,
    input  logic [1:0]        snp_cmd,
    input  logic [TAG_W-1:0]  snp_tag,
    input  logic [SRC_W-1:0]  snp_src,
    input  line_st_t          l_st,
    input  logic [TAG_W-1:0]  l_tag,
    input  logic [DATA_W-1:0] l_data,
    output logic              act,
    output line_st_t          new_st,
    output logic              abort,
    output logic [DATA_W-1:0] wb_data
);
    logic match;

    assign match = snp_valid && (snp_src != SRC_W'(MY_ID)) &&
                   (l_st != LS_INV) && (l_tag == snp_tag);

    always_comb begin
        act     = 1'b0;
        new_st  = l_st;
        abort   = 1'b0;
        wb_data = '0;
        if (match) begin
            unique case (l_st)
                LS_SHR: begin
                    if (snp_cmd == BC_WRMISS) begin
                        act    = 1'b1;
                        new_st = LS_INV;
                    end
                end
                LS_EXC: begin
                    if (snp_cmd == BC_RDMISS || snp_cmd == BC_WRMISS) begin
                        act     = 1'b1;
                        abort   = 1'b1;
                        wb_data = l_data;
                        new_st  = (snp_cmd == BC_RDMISS) ? LS_SHR : LS_INV;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/scc_ctrl.sv
module scc_ctrl
    import scc_pkg::*;
#(
    parameter int IDX_W  = 3,
    parameter int TAG_W  = 7,
    parameter int DATA_W = 16,
    localparam int ADDR_W = IDX_W + TAG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [IDX_W-1:0]  cpu_idx,
    input  logic [TAG_W-1:0]  cpu_tag,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ack,
    output logic [DATA_W-1:0] cpu_rdata,
    input  line_st_t          l_st,
    input  logic [TAG_W-1:0]  l_tag,
    input  logic [DATA_W-1:0] l_data,
    input  logic              snp_here,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic              bus_valid,
    output logic [1:0]        bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_data,
    input  logic              fill_valid,
    input  logic [DATA_W-1:0] fill_data,
    output logic              u_we,
    output line_st_t          u_st,
    output logic [TAG_W-1:0]  u_tag,
    output logic [DATA_W-1:0] u_data
);
    ctl_st_t           st_q, st_d;
    logic [DATA_W-1:0] rdata_q, rdata_d;
    logic              tag_eq, is_hit, dirty_victim;
    line_st_t          fill_st;

    assign tag_eq       = (l_tag == cpu_tag);
    assign is_hit       = (l_st != LS_INV) && tag_eq && (!cpu_we || l_st == LS_EXC);
    assign dirty_victim = (l_st == LS_EXC) && !tag_eq;
    assign fill_st      = cpu_we ? LS_EXC : LS_SHR;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= C_IDLE;
            rdata_q <= '0;
        end else begin
            st_q    <= st_d;
            rdata_q <= rdata_d;
        end
    end

    always_comb begin
        st_d      = st_q;
        rdata_d   = rdata_q;
        bus_req   = 1'b0;
        bus_valid = 1'b0;
        bus_cmd   = BC_NONE;
        bus_addr  = '0;
        bus_data  = '0;
        u_we      = 1'b0;
        u_st      = l_st;
        u_tag     = l_tag;
        u_data    = l_data;
        unique case (st_q)
            C_IDLE: begin
                if (cpu_req && !snp_here) begin
                    if (is_hit) begin
                        st_d    = C_DONE;
                        rdata_d = cpu_we ? cpu_wdata : l_data;
                        if (cpu_we) begin
                            u_we   = 1'b1;
                            u_data = cpu_wdata;
                        end
                    end else if (dirty_victim) begin
                        st_d = C_WBREQ;
                    end else begin
                        st_d = C_MISSREQ;
                    end
                end
            end
            C_WBREQ: begin
                bus_req = 1'b1;
                if (snp_here) begin
                    st_d = C_IDLE;
                end else if (bus_gnt) begin
                    bus_valid = 1'b1;
                    bus_cmd   = BC_WRBACK;
                    bus_addr  = {l_tag, cpu_idx};
                    bus_data  = l_data;
                    u_we      = 1'b1;
                    u_st      = LS_INV;
                    st_d      = C_MISSREQ;
                end
            end
            C_MISSREQ: begin
                bus_req = 1'b1;
                if (snp_here) begin
                    st_d = C_IDLE;
                end else if (bus_gnt) begin
                    bus_valid = 1'b1;
                    bus_cmd   = cpu_we ? BC_WRMISS : BC_RDMISS;
                    bus_addr  = {cpu_tag, cpu_idx};
                    u_we      = 1'b1;
                    u_st      = fill_st;
                    u_tag     = cpu_tag;
                    st_d      = C_FILL;
                end
            end
            C_FILL: begin
                if (fill_valid) begin
                    u_we    = 1'b1;
                    u_st    = fill_st;
                    u_tag   = cpu_tag;
                    u_data  = cpu_we ? cpu_wdata : fill_data;
                    rdata_d = u_data;
                    st_d    = C_DONE;
                end
            end
            C_DONE: st_d = C_IDLE;
            default: st_d = C_IDLE;
        endcase
    end

    assign cpu_ack   = (st_q == C_DONE);
    assign cpu_rdata = rdata_q;
endmodule

// File: rtl/snoop_cache_ctrl.sv
module snoop_cache_ctrl
    import scc_pkg::*;
#(
    parameter int LINES  = 8,
    parameter int ADDR_W = 10,
    parameter int DATA_W = 16,
    parameter int SRC_W  = 2,
    parameter int MY_ID  = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ack,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic              bus_valid,
    output logic [1:0]        bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_data,
    input  logic              fill_valid,
    input  logic [DATA_W-1:0] fill_data,
    input  logic              snp_valid,
    input  logic [1:0]        snp_cmd,
    input  logic [ADDR_W-1:0] snp_addr,
    input  logic [SRC_W-1:0]  snp_src,
    output logic              snp_abort,
    output logic [DATA_W-1:0] snp_data
);
    localparam int IDX_W = $clog2(LINES);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic [IDX_W-1:0]  c_idx, s_idx;
    logic [TAG_W-1:0]  c_tag_in, s_tag_in;
    line_st_t          c_st, s_st, s_new_st, u_st;
    logic [TAG_W-1:0]  c_tag, s_tag, u_tag;
    logic [DATA_W-1:0] c_data, s_data, u_data;
    logic              s_act, u_we, snp_here;

    assign c_idx    = cpu_addr[IDX_W-1:0];
    assign c_tag_in = cpu_addr[ADDR_W-1:IDX_W];
    assign s_idx    = snp_addr[IDX_W-1:0];
    assign s_tag_in = snp_addr[ADDR_W-1:IDX_W];
    assign snp_here = s_act && (s_idx == c_idx);

    scc_line_store #(.LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .c_idx(c_idx), .c_st(c_st), .c_tag(c_tag), .c_data(c_data),
        .s_idx(s_idx), .s_st(s_st), .s_tag(s_tag), .s_data(s_data),
        .s_we(s_act), .s_new_st(s_new_st),
        .u_we(u_we), .u_idx(c_idx), .u_st(u_st), .u_tag(u_tag), .u_data(u_data)
    );

    scc_snoop #(.TAG_W(TAG_W), .DATA_W(DATA_W), .SRC_W(SRC_W), .MY_ID(MY_ID)) u_snoop (
        .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_tag(s_tag_in), .snp_src(snp_src),
        .l_st(s_st), .l_tag(s_tag), .l_data(s_data),
        .act(s_act), .new_st(s_new_st), .abort(snp_abort), .wb_data(snp_data)
    );

    scc_ctrl #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_idx(c_idx), .cpu_tag(c_tag_in),
        .cpu_wdata(cpu_wdata), .cpu_ack(cpu_ack), .cpu_rdata(cpu_rdata),
        .l_st(c_st), .l_tag(c_tag), .l_data(c_data), .snp_here(snp_here),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_valid(bus_valid), .bus_cmd(bus_cmd),
        .bus_addr(bus_addr), .bus_data(bus_data),
        .fill_valid(fill_valid), .fill_data(fill_data),
        .u_we(u_we), .u_st(u_st), .u_tag(u_tag), .u_data(u_data)
    );
endmodule

// File: rtl/scc_checker.sv
module scc_checker #(
    parameter int SRC_W = 2,
    parameter int MY_ID = 0
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cpu_ack,
    input logic             bus_req,
    input logic             bus_gnt,
    input logic             bus_valid,
    input logic [1:0]       bus_cmd,
    input logic             snp_valid,
    input logic [1:0]       snp_cmd,
    input logic [SRC_W-1:0] snp_src,
    input logic             snp_abort
);
    a_r11_valid_under_grant: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> (bus_gnt && bus_req));

    a_r11_valid_has_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> (bus_cmd != 2'd0));

    a_r10_own_snoop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && snp_src == SRC_W'(MY_ID)) |-> !snp_abort);

    a_r7_abort_needs_miss: assert property (@(posedge clk) disable iff (!rst_n)
        snp_abort |-> (snp_valid && (snp_cmd == 2'd1 || snp_cmd == 2'd2)));

    a_r4_ack_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ack |=> !cpu_ack);

    a_r9_no_req_during_ack: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ack |-> !bus_req);
endmodule

bind snoop_cache_ctrl scc_checker #(.SRC_W(SRC_W), .MY_ID(MY_ID)) u_scc_checker (
    .clk(clk), .rst_n(rst_n), .cpu_ack(cpu_ack), .bus_req(bus_req), .bus_gnt(bus_gnt),
    .bus_valid(bus_valid), .bus_cmd(bus_cmd), .snp_valid(snp_valid), .snp_cmd(snp_cmd),
    .snp_src(snp_src), .snp_abort(snp_abort)
);

// File: tb/tb_snoop_cache_ctrl.sv
module tb_snoop_cache_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 10;
    localparam int DW = 16;
    localparam logic [1:0] RD = 2'd1, WR = 2'd2, WB = 2'd3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_req = 1'b0, cpu_we = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [DW-1:0] cpu_wdata = '0;
    logic          cpu_ack;
    logic [DW-1:0] cpu_rdata;
    logic          bus_req, bus_valid;
    logic          bus_gnt = 1'b0;
    logic [1:0]    bus_cmd;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_data;
    logic          fill_valid = 1'b0;
    logic [DW-1:0] fill_data = '0;
    logic          snp_valid = 1'b0;
    logic [1:0]    snp_cmd = '0;
    logic [AW-1:0] snp_addr = '0;
    logic [1:0]    snp_src = '0;
    logic          snp_abort;
    logic [DW-1:0] snp_data;

    int tests = 0, fails = 0;
    bit hold_gnt = 1'b0;
    bit done = 1'b0;

    typedef struct {
        logic [1:0]    cmd;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        bit            chk;
        string         req;
    } bus_item_t;

    bus_item_t     bus_q[$];
    logic [DW-1:0] rd_q[$];
    string         rd_tag_q[$];
    logic [DW-1:0] mem [1 << AW];

    always #(CLK_PERIOD / 2) clk = ~clk;

    snoop_cache_ctrl dut (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_ack(cpu_ack), .cpu_rdata(cpu_rdata),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_valid(bus_valid), .bus_cmd(bus_cmd),
        .bus_addr(bus_addr), .bus_data(bus_data), .fill_valid(fill_valid), .fill_data(fill_data),
        .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr), .snp_src(snp_src),
        .snp_abort(snp_abort), .snp_data(snp_data)
    );

    function automatic logic [DW-1:0] init_val(int a);
        return DW'(a * 3 + 16'h0100);
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic exp_bus(string req, logic [1:0] c, logic [AW-1:0] a, logic [DW-1:0] d, bit k);
        bus_item_t it;
        it.cmd = c; it.addr = a; it.data = d; it.chk = k; it.req = req;
        bus_q.push_back(it);
    endtask

    task automatic cpu_op(string req, bit we, logic [AW-1:0] a, logic [DW-1:0] wd, logic [DW-1:0] exp);
        @(negedge clk);
        cpu_we = we; cpu_addr = a; cpu_wdata = wd; cpu_req = 1'b1;
        rd_q.push_back(exp);
        rd_tag_q.push_back(req);
        do begin
            @(negedge clk);
            #3;
        end while (!cpu_ack);
        cpu_req = 1'b0;
        chk(req, "bus commands left over", 32'(bus_q.size()), 0);
    endtask

    task automatic snoop(string req, logic [1:0] c, logic [AW-1:0] a, logic [1:0] src,
                         bit exp_abort, logic [DW-1:0] exp_data);
        @(negedge clk);
        snp_valid = 1'b1; snp_cmd = c; snp_addr = a; snp_src = src;
        #2;
        chk(req, "snp_abort", 32'(snp_abort), 32'(exp_abort));
        if (exp_abort) begin
            chk(req, "snp_data", 32'(snp_data), 32'(exp_data));
            mem[a] = snp_data;
        end
        @(negedge clk);
        snp_valid = 1'b0;
    endtask

    // processor response monitor
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (cpu_ack) begin
                if (rd_q.size() == 0) begin
                    tests++; fails++;
                    $display("FAIL R4 unexpected cpu_ack: actual 1 expected 0");
                end else begin
                    chk(rd_tag_q.pop_front(), "cpu_rdata", 32'(cpu_rdata), 32'(rd_q.pop_front()));
                end
            end
        end
    end

    // bus and memory model with command monitor
    initial begin
        bit            fill_pend = 1'b0;
        logic [AW-1:0] fill_addr = '0;
        forever begin
            @(negedge clk);
            bus_gnt = 1'b0;
            fill_valid = 1'b0;
            if (fill_pend) begin
                fill_valid = 1'b1;
                fill_data = mem[fill_addr];
                fill_pend = 1'b0;
            end else if (rst_n && bus_req && !hold_gnt) begin
                bus_gnt = 1'b1;
            end
            #2;
            if (bus_valid) begin
                if (bus_q.size() == 0) begin
                    tests++; fails++;
                    $display("FAIL R4 unexpected bus command: actual %0d expected none", bus_cmd);
                end else begin
                    bus_item_t it;
                    it = bus_q.pop_front();
                    chk(it.req, "bus_cmd", 32'(bus_cmd), 32'(it.cmd));
                    chk(it.req, "bus_addr", 32'(bus_addr), 32'(it.addr));
                    if (it.chk) chk(it.req, "bus_data", 32'(bus_data), 32'(it.data));
                end
                if (bus_cmd == WB) mem[bus_addr] = bus_data;
                else begin
                    fill_pend = 1'b1;
                    fill_addr = bus_addr;
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < (1 << AW); i++) mem[i] = init_val(i);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #2;
        chk("R1", "cpu_ack", 32'(cpu_ack), 0);
        chk("R1", "bus_req", 32'(bus_req), 0);
        chk("R1", "bus_valid", 32'(bus_valid), 0);
        chk("R1", "snp_abort", 32'(snp_abort), 0);

        // R1/R2: first load after reset must miss
        exp_bus("R2", RD, 10'h011, '0, 0);
        cpu_op("R2", 0, 10'h011, '0, init_val('h011));
        // R4: load hit in Shared
        cpu_op("R4", 0, 10'h011, '0, init_val('h011));
        // R3: store to Shared is a write miss
        exp_bus("R3", WR, 10'h011, '0, 0);
        cpu_op("R3", 1, 10'h011, 16'hBEEF, 16'hBEEF);
        // R4: store and load hit in Exclusive
        cpu_op("R4", 1, 10'h011, 16'h1234, 16'h1234);
        cpu_op("R4", 0, 10'h011, '0, 16'h1234);
        // R5: conflicting load evicts dirty line
        exp_bus("R5", WB, 10'h011, 16'h1234, 1);
        exp_bus("R5", RD, 10'h021, '0, 0);
        cpu_op("R5", 0, 10'h021, '0, init_val('h021));
        chk("R5", "memory after write-back", 32'(mem['h011]), 32'h1234);
        // R6: snooped write miss invalidates a Shared line
        snoop("R6", WR, 10'h021, 2'd1, 0, '0);
        exp_bus("R6", RD, 10'h021, '0, 0);
        cpu_op("R6", 0, 10'h021, '0, init_val('h021));
        // R3: store to Invalid
        exp_bus("R3", WR, 10'h032, '0, 0);
        cpu_op("R3", 1, 10'h032, 16'h5555, 16'h5555);
        // R7: snooped read miss on Exclusive
        snoop("R7", RD, 10'h032, 2'd1, 1, 16'h5555);
        cpu_op("R7", 0, 10'h032, '0, 16'h5555);
        exp_bus("R7", WR, 10'h032, '0, 0);
        cpu_op("R7", 1, 10'h032, 16'h6666, 16'h6666);
        // R10: own snoop ignored
        snoop("R10", WR, 10'h032, 2'd0, 0, '0);
        cpu_op("R10", 1, 10'h032, 16'h7777, 16'h7777);
        // R8: snooped write miss on Exclusive
        snoop("R8", WR, 10'h032, 2'd1, 1, 16'h7777);
        exp_bus("R8", RD, 10'h032, '0, 0);
        cpu_op("R8", 0, 10'h032, '0, 16'h7777);
        // R9: restart when a snoop takes the victim during the grant wait
        exp_bus("R9", WR, 10'h00D, '0, 0);
        cpu_op("R9", 1, 10'h00D, 16'hAAAA, 16'hAAAA);
        hold_gnt = 1'b1;
        exp_bus("R9", WR, 10'h015, '0, 0);
        fork
            cpu_op("R9", 1, 10'h015, 16'hBBBB, 16'hBBBB);
        join_none
        repeat (4) @(negedge clk);
        #2;
        chk("R9", "bus_req while waiting", 32'(bus_req), 1);
        chk("R9", "cpu_ack while waiting", 32'(cpu_ack), 0);
        snoop("R9", RD, 10'h00D, 2'd1, 1, 16'hAAAA);
        hold_gnt = 1'b0;
        wait fork;
        exp_bus("R9", WB, 10'h015, 16'hBBBB, 1);
        exp_bus("R9", RD, 10'h00D, '0, 0);
        cpu_op("R9", 0, 10'h00D, '0, 16'hAAAA);

        repeat (3) @(negedge clk);
        chk("R4", "pending responses", 32'(rd_q.size()), 0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule